// File: doc/BRIEF.md
# Skip-Range Loadable Counter

This block is an 8-bit counter that walks a fixed, broken sequence: it counts up from 3 to 13, leaps straight to 19, counts up to 29, and then returns to 3. The sequence repeats every 22 clock cycles. The values 14 to 18 never appear, and neither does any value above 29.

The counting element is a plain loadable core built from cascaded 4-bit stages. Each stage has a synchronous load, a count enable and a terminal-count flag, and each upper stage is enabled by the carry of the stage below it. The counter does not count through the gap. A small decoder watches the current count and, at the two break points, asserts the core's load and places the next value on the core's data inputs.

A synchronous, active-high start input loads the starting value. It takes priority over every decoded load. The outputs are the registered count and the core's terminal-count flag.

Top module: `skip_range_counter`

## Requirements
- R1: A clock edge with `rst` high sets `count` to 3, whatever the current count, including 13 and 29.
- R2: With `rst` low and `count` in 3..12, the next edge sets `count` to its value plus 1.
- R3: With `rst` low and `count` at 13, the next edge sets `count` to 19.
- R4: With `rst` low and `count` in 19..28, the next edge sets `count` to its value plus 1.
- R5: With `rst` low and `count` at 29, the next edge sets `count` to 3.
- R6: After the first start, `count` never shows a value in 14..18 and never a value above 29.
- R7: `carry` is 1 only when `count` is 255, so it stays 0 throughout the legal sequence.
- R8: With `rst` held low, the sequence repeats with a period of exactly 22 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high start; loads the value 3 |
| count | output | 8 | Registered counter value |
| carry | output | 1 | Core terminal-count flag, high only at 255 |

## Verification
On every cycle, the assertions check four things: the start load, both decoded jumps (13 to 19 and 29 to 3), the plus-one steps inside the two runs, and that no value from the gap or above 29 ever appears. Inside each 4-bit stage, they also check load, increment and hold, and they tie `carry` to the all-ones count. Only the bench scenarios can show the 22-cycle period. The same holds for a start that lands exactly on a break point and for the complete ordered list of values across more than one pass.

// File: rtl/skip_range_counter_pkg.sv
package skip_range_counter_pkg;

  // Decision taken by the load steering logic on each cycle
  typedef enum logic [1:0] {
    STEER_RUN  = 2'd0,  // plain increment
    STEER_JUMP = 2'd1,  // end of low run: load the high run start
    STEER_WRAP = 2'd2,  // end of high run: load the sequence start
    STEER_INIT = 2'd3   // external start: load the sequence start
  } steer_e;

endpackage

// File: rtl/skip_range_counter_stage.sv
module skip_range_counter_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         ld,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         co
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (ld)
      q <= d;
    else if (en)
      q <= q + 1'b1;
  end

  assign co = (q == TOP);

  // Assertion support: becomes 1 after the first load
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= primed | ld;

  // R1
  stage_load_chk: assert property (@(posedge clk) disable iff (!primed)
    ld |=> (q == $past(d)));
  // R2
  stage_incr_chk: assert property (@(posedge clk) disable iff (!primed)
    (!ld && en) |=> (q == W'($past(q) + 1'b1)));
  // R4
  stage_hold_chk: assert property (@(posedge clk) disable iff (!primed)
    (!ld && !en) |=> $stable(q));

endmodule

// File: rtl/skip_range_counter_core.sv
module skip_range_counter_core #(
  parameter int STAGE_W  = 4,
  parameter int N_STAGES = 2,
  localparam int CW      = STAGE_W * N_STAGES
) (
  input  logic          clk,
  input  logic          ld,
  input  logic          en,
  input  logic [CW-1:0] d,
  output logic [CW-1:0] q,
  output logic          co
);

  logic [N_STAGES:0]   chain;
  logic [N_STAGES-1:0] stage_co;

  assign chain[0] = en;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    skip_range_counter_stage #(.W(STAGE_W)) u_stage (
      .clk (clk),
      .ld  (ld),
      .en  (chain[i]),
      .d   (d[i*STAGE_W +: STAGE_W]),
      .q   (q[i*STAGE_W +: STAGE_W]),
      .co  (stage_co[i])
    );
    assign chain[i+1] = chain[i] & stage_co[i];
  end

  assign co = &stage_co;

endmodule

// File: rtl/skip_range_counter_steer.sv
module skip_range_counter_steer
  import skip_range_counter_pkg::*;
#(
  parameter int CW        = 8,
  parameter int START     = 3,
  parameter int LOW_END   = 13,
  parameter int HIGH_BASE = 19,
  parameter int HIGH_END  = 29
) (
  input  logic          rst,
  input  logic [CW-1:0] q,
  output logic          ld,
  output logic          en,
  output logic [CW-1:0] d
);

  localparam logic [CW-1:0] START_V = CW'(START);
  localparam logic [CW-1:0] LEND_V  = CW'(LOW_END);
  localparam logic [CW-1:0] HBASE_V = CW'(HIGH_BASE);
  localparam logic [CW-1:0] HEND_V  = CW'(HIGH_END);

  steer_e sel;

  always_comb begin
    if (rst)
      sel = STEER_INIT;
    else if (q == LEND_V)
      sel = STEER_JUMP;
    else if (q == HEND_V)
      sel = STEER_WRAP;
    else
      sel = STEER_RUN;
  end

  always_comb begin
    en = 1'b1;
    ld = (sel != STEER_RUN);
    unique case (sel)
      STEER_JUMP: d = HBASE_V;
      default:    d = START_V;
    endcase
  end

endmodule

// File: rtl/skip_range_counter.sv
module skip_range_counter #(
  parameter int STAGE_W   = 4,
  parameter int N_STAGES  = 2,
  parameter int START     = 3,
  parameter int LOW_END   = 13,
  parameter int HIGH_BASE = 19,
  parameter int HIGH_END  = 29,
  localparam int CW       = STAGE_W * N_STAGES
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] count,
  output logic          carry
);

  logic          core_ld;
  logic          core_en;
  logic [CW-1:0] core_d;

  skip_range_counter_steer #(
    .CW(CW), .START(START), .LOW_END(LOW_END),
    .HIGH_BASE(HIGH_BASE), .HIGH_END(HIGH_END)
  ) u_steer (
    .rst (rst),
    .q   (count),
    .ld  (core_ld),
    .en  (core_en),
    .d   (core_d)
  );

  skip_range_counter_core #(
    .STAGE_W(STAGE_W), .N_STAGES(N_STAGES)
  ) u_core (
    .clk (clk),
    .ld  (core_ld),
    .en  (core_en),
    .d   (core_d),
    .q   (count),
    .co  (carry)
  );

  // Assertion support: becomes 1 after the first start
  logic started = 1'b0;
  always_ff @(posedge clk) if (rst) started <= 1'b1;

  // R1
  start_load_chk: assert property (@(posedge clk) disable iff (!started)
    rst |=> (count == CW'(START)));
  // R2
  low_step_chk: assert property (@(posedge clk) disable iff (!started)
    (!rst && count >= CW'(START) && count < CW'(LOW_END))
      |=> (count == CW'($past(count) + 1'b1)));
  // R3
  low_jump_chk: assert property (@(posedge clk) disable iff (!started)
    (!rst && count == CW'(LOW_END)) |=> (count == CW'(HIGH_BASE)));
  // R4
  high_step_chk: assert property (@(posedge clk) disable iff (!started)
    (!rst && count >= CW'(HIGH_BASE) && count < CW'(HIGH_END))
      |=> (count == CW'($past(count) + 1'b1)));
  // R5
  high_wrap_chk: assert property (@(posedge clk) disable iff (!started)
    (!rst && count == CW'(HIGH_END)) |=> (count == CW'(START)));
  // R6
  no_gap_chk: assert property (@(posedge clk) disable iff (!started || rst)
    ##1 !((count > CW'(LOW_END) && count < CW'(HIGH_BASE)) || count > CW'(HIGH_END)));
  // R7
  carry_top_chk: assert property (@(posedge clk) disable iff (!started)
    carry == (count == {CW{1'b1}}));

endmodule

// File: tb/skip_range_counter_bench.sv
module skip_range_counter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] count;
  logic       carry;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  skip_range_counter u_skip_range_counter (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .carry (carry)
  );

  function automatic int model_next(input int c);
    if (c == 13) return 19;
    if (c == 29) return 3;
    return c + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R1: start from an unknown state
  task automatic t_reset();
    rst = 1'b1;
    step();
    check(count == 8'd3, "R1 start value", count, 3);
    check(carry == 1'b0, "R7 carry after start", carry, 0);
    rst = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7: walk two full passes against the model
  task automatic t_sequence();
    int exp = 3;
    for (int i = 0; i < 44; i++) begin
      exp = model_next(exp);
      step();
      if (exp == 19)
        check(count == 8'(exp), "R3 jump 13->19", count, exp);
      else if (exp == 3)
        check(count == 8'(exp), "R5 wrap 29->3", count, exp);
      else if (exp <= 13)
        check(count == 8'(exp), "R2 low run step", count, exp);
      else
        check(count == 8'(exp), "R4 high run step", count, exp);
      check(!((count > 13 && count < 19) || count > 29), "R6 no gap value", count, exp);
      check(carry == 1'b0, "R7 carry low in sequence", carry, 0);
    end
  endtask

  // R8: period of 22
  task automatic t_period();
    int first;
    int n = 0;
    first = count;
    do begin
      step();
      n++;
    end while (count != 8'(first) && n < 100);
    check(n == 22, "R8 period", n, 22);
  endtask

  // R1: start has priority at both break points
  task automatic t_start_priority();
    while (count != 8'd13) step();
    rst = 1'b1;
    step();
    check(count == 8'd3, "R1 start beats jump at 13", count, 3);
    rst = 1'b0;
    while (count != 8'd29) step();
    rst = 1'b1;
    step();
    check(count == 8'd3, "R1 start beats wrap at 29", count, 3);
    rst = 1'b0;
    step();
    check(count == 8'd4, "R2 resumes after start", count, 4);
  endtask

  // R1: start in the middle of the high run
  task automatic t_start_mid();
    while (count != 8'd23) step();
    rst = 1'b1;
    step();
    check(count == 8'd3, "R1 start mid high run", count, 3);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence();
    t_period();
    t_start_priority();
    t_start_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule